// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block sits on the memory side of a NOR-style flash array. It decides which word address the internal array port reads in each clock, when the returned word is valid, and how the WAIT pin is driven. A 16-bit configuration word, written through a one-cycle write strobe, selects the read behaviour. In asynchronous page mode the array address follows the start address input and data is always valid. In synchronous burst mode an address strobe starts a burst. The burst waits a programmable number of clocks, then steps through 4, 8 or 16 words, or runs without end. Each word is held for one or two clocks, and the address either wraps inside its aligned window or keeps incrementing.

The array is modelled as a combinational read port. The word on `arr_rdata` is passed to `rd_data`. A configuration word with a reserved or unsupported setting is not applied: the block loads the reset defaults and raises a sticky error flag.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration is 16'hBFCF: asynchronous mode, latency 7, WAIT active high, two-clock hold, early WAIT, linear, no wrap, continuous. `data_valid` is 1, `wait_o` is 0 and `cfg_err` is 0.
- R2: With bit 15 set (asynchronous), `arr_addr` equals `start_addr` in the same cycle, `data_valid` is 1, WAIT is at its deasserted level, and `addr_strobe` starts no burst.
- R3: With bit 15 clear, a strobe sampled at edge t0 gives `data_valid` 0 for L cycles, where L is bits 13:11 (2..7). The first word is valid in the cycle after edge t0+L, at address `start_addr`.
- R4: Bit 9 sets the hold: 0 keeps each word for one clock, 1 keeps it for two. `data_valid` stays 1 across the hold and the address advances once per hold period.
- R5: Bits 2:0 set the length: 001 gives 4 words, 010 gives 8, 011 gives 16, and 111 is continuous. After the last word of a fixed burst, `data_valid` and WAIT return to inactive.
- R6: With bit 3 clear and a fixed length N, word i sits at address (start & ~(N-1)) | ((start+i) & (N-1)).
- R7: With bit 3 set, or with continuous length, word i sits at address start+i, crossing window boundaries.
- R8: Bit 10 sets WAIT polarity: 1 drives the asserted WAIT high, 0 drives it low. Outside a burst, WAIT sits at the deasserted level.
- R9: WAIT is asserted during the latency of a burst. With bit 8 clear it deasserts in the first valid data cycle. With bit 8 set it deasserts H cycles earlier, where H is the hold length.
- R10: A write that has bit 14 set, bits 5:4 not zero, bit 7 or bit 6 clear, a latency code of 0 or 1, or a length code outside {001,010,011,111} loads the reset defaults and sets `cfg_err`. `cfg_err` clears only at reset.
- R11: Latency code 2 with bit 9 set and bit 8 set is rejected in the same way as R10.
- R12: A new strobe during a burst abandons it and restarts the timing from the new strobe and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| addr_strobe | input | 1 | Starts a burst in synchronous mode |
| start_addr | input | AW | Start word address |
| arr_addr | output | AW | Word address to the array port |
| arr_rdata | input | DW | Word read from the array port |
| rd_data | output | DW | Read data out |
| data_valid | output | 1 | Read data is valid |
| wait_o | output | 1 | WAIT, programmable polarity |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
Some checks run on every cycle. The error flag never clears once set. The held configuration never carries reserved or rejected fields. No data is valid in the cycle after a synchronous strobe. The address holds still during the first half of a two-clock hold. In wrap mode the address never leaves its window. The cycle-exact timing of latency, WAIT deassertion, burst end and address order can only be shown by the bench. It drives random legal configurations and directed boundary cases, such as wrap at the window top, the rejected combination and a restart in mid-burst, and compares each cycle with a model.

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          addr_strobe,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          data_valid,
  output logic          wait_o,
  output logic          cfg_err
);
  localparam logic [15:0] CFG_DEFAULT = 16'hBFCF;

  logic [15:0]   cfg;
  logic          busy, hph;
  logic [2:0]    lcnt;
  logic [3:0]    widx, last_idx;
  logic [AW-1:0] addr, mask, inc, nxt;

  wire       async_md = cfg[15];
  wire [2:0] lat      = cfg[13:11];
  wire       wpol     = cfg[10];
  wire       hold2    = cfg[9];
  wire       early    = cfg[8];
  wire       nowrap   = cfg[3];
  wire [2:0] blen     = cfg[2:0];
  wire       cont     = (blen == 3'b111);

  wire [2:0] wl = cfg_wdata[13:11];
  wire [2:0] wb = cfg_wdata[2:0];
  wire wr_ok = !cfg_wdata[14] && (cfg_wdata[5:4] == 2'b00) && cfg_wdata[7] && cfg_wdata[6]
            && (wl >= 3'd2)
            && (wb == 3'd1 || wb == 3'd2 || wb == 3'd3 || wb == 3'd7)
            && !(wl == 3'd2 && cfg_wdata[9] && cfg_wdata[8]);

  always_comb begin
    case (blen)
      3'd1:    last_idx = 4'd3;
      3'd2:    last_idx = 4'd7;
      default: last_idx = 4'd15;
    endcase
  end

  assign mask = {{(AW-4){1'b0}}, last_idx};
  assign inc  = addr + 1'b1;
  assign nxt  = (!nowrap && !cont) ? ((addr & ~mask) | (inc & mask)) : inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_DEFAULT; cfg_err <= 1'b0;
      busy <= 1'b0; lcnt <= '0; hph <= 1'b0; widx <= '0; addr <= '0;
    end else begin
      if (cfg_we) begin
        if (wr_ok) cfg <= cfg_wdata;
        else begin
          cfg <= CFG_DEFAULT;
          cfg_err <= 1'b1;
        end
      end
      if (addr_strobe && !async_md) begin
        busy <= 1'b1; lcnt <= lat; hph <= 1'b0; widx <= '0; addr <= start_addr;
      end else if (busy) begin
        if (lcnt != 3'd0) lcnt <= lcnt - 3'd1;
        else if (hold2 && !hph) hph <= 1'b1;
        else begin
          hph  <= 1'b0;
          addr <= nxt;
          widx <= widx + 4'd1;
          if (!cont && widx == last_idx) busy <= 1'b0;
        end
      end
    end
  end

  wire in_data  = busy && (lcnt == 3'd0);
  wire [2:0] wthr = early ? (hold2 ? 3'd2 : 3'd1) : 3'd0;
  wire wait_act = !async_md && busy && (lcnt > wthr);

  assign data_valid = async_md | in_data;
  assign arr_addr   = async_md ? start_addr : addr;
  assign rd_data    = arr_rdata;
  assign wait_o     = wpol ? wait_act : ~wait_act;

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r10_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[14] && cfg[5:4] == 2'b00 && cfg[13:11] >= 3'd2 && cfg[7] && cfg[6]
    && !(cfg[13:11] == 3'd2 && cfg[9] && cfg[8]));

  a_r3_no_data_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && !async_md && !cfg_we) |=> !data_valid);

  a_r4_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && hold2 && !hph && !addr_strobe && !cfg_we) |=> $stable(arr_addr));

  a_r6_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(addr_strobe) && !$past(cfg_we) && !nowrap && !cont)
      |-> ((addr & ~mask) == ($past(addr) & ~mask)));
endmodule

// File: tb/burst_read_seq_tb.sv
module burst_read_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          addr_strobe = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_rdata, rd_data;
  logic          data_valid, wait_o, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign arr_rdata = arr_addr ^ 16'h5A3C;

  burst_read_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .addr_strobe(addr_strobe), .start_addr(start_addr), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .data_valid(data_valid),
    .wait_o(wait_o), .cfg_err(cfg_err));

  function automatic logic [15:0] mk(input bit md, input int lat, input bit pol,
                                     input bit h2, input bit ea, input bit nw, input int bl);
    return {md, 1'b0, 3'(lat), pol, h2, ea, 1'b1, 1'b1, 2'b00, nw, 3'(bl)};
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] c, input logic [15:0] st, input int i);
    logic [15:0] m;
    m = (c[2:0] == 3'd1) ? 16'd3 : (c[2:0] == 3'd2) ? 16'd7 : 16'd15;
    if (!c[3] && c[2:0] != 3'd7) return (st & ~m) | ((st + 16'(i)) & m);
    return st + 16'(i);
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; addr_strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] c);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic burst(input logic [15:0] c, input logic [15:0] st, input int ncyc, input string req);
    int L, H, N, idx;
    bit ev, act, ew;
    logic [15:0] ea;
    L = int'(c[13:11]); H = c[9] ? 2 : 1;
    N = (c[2:0] == 3'd1) ? 4 : (c[2:0] == 3'd2) ? 8 : 16;
    @(negedge clk); addr_strobe = 1'b1; start_addr = st;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      addr_strobe = 1'b0; start_addr = 16'($urandom);
      ea = '0;
      if (k <= L) begin
        ev = 1'b0; act = (L - (k - 1)) > (c[8] ? H : 0);
      end else begin
        idx = (k - L - 1) / H;
        if (c[2:0] != 3'd7 && idx >= N) begin ev = 1'b0; act = 1'b0; end
        else begin ev = 1'b1; act = 1'b0; ea = exp_addr(c, st, idx); end
      end
      ew = c[10] ? act : !act;
      check(data_valid == ev && wait_o == ew && (!ev || (arr_addr == ea && rd_data == (ea ^ 16'h5A3C))),
            req, $sformatf("cyc%0d v=%0b w=%0b a=%h", k, data_valid, wait_o, arr_addr),
            $sformatf("v=%0b w=%0b a=%h", ev, ew, ea));
    end
  endtask

  function automatic int burst_cycles(input logic [15:0] c);
    int H, N;
    H = c[9] ? 2 : 1;
    N = (c[2:0] == 3'd1) ? 4 : (c[2:0] == 3'd2) ? 8 : (c[2:0] == 3'd3) ? 16 : 20;
    return int'(c[13:11]) + H * N + 3;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    int lat, bl;
    void'($urandom(32'd1234));
    do_reset();

    check(data_valid == 1'b1 && wait_o == 1'b0 && cfg_err == 1'b0, "R1 reset",
          $sformatf("v=%0b w=%0b e=%0b", data_valid, wait_o, cfg_err), "v=1 w=0 e=0");

    start_addr = 16'h1234; #1;
    check(arr_addr == 16'h1234 && data_valid, "R2 async addr", $sformatf("%h", arr_addr), "1234");
    @(negedge clk); addr_strobe = 1'b1; start_addr = 16'h0040;
    @(negedge clk); addr_strobe = 1'b0;
    check(data_valid && wait_o == 1'b0 && arr_addr == 16'h0040, "R2 strobe ignored",
          $sformatf("v=%0b w=%0b a=%h", data_valid, wait_o, arr_addr), "v=1 w=0 a=0040");

    c = mk(0, 3, 1, 0, 0, 0, 1); wr_cfg(c); burst(c, 16'h00FE, 12, "R6 wrap R3 R9");
    c = mk(0, 3, 1, 0, 0, 1, 1); wr_cfg(c); burst(c, 16'h00FE, 12, "R7 nowrap");
    c = mk(0, 4, 0, 1, 1, 1, 1); wr_cfg(c); burst(c, 16'h0010, 16, "R8 pol low R9 early R4");
    c = mk(0, 5, 1, 1, 0, 0, 2); wr_cfg(c); burst(c, 16'h0105, 25, "R4 hold2 R6 R5");
    c = mk(0, 2, 1, 0, 1, 1, 3); wr_cfg(c); burst(c, 16'h7FFA, 22, "R5 len16 R7");
    c = mk(0, 7, 0, 0, 0, 0, 7); wr_cfg(c); burst(c, 16'hFFF0, 40, "R5 continuous R7");
    c = mk(0, 3, 1, 0, 0, 1, 2); wr_cfg(c);
    burst(c, 16'h0200, 6, "R12 first"); burst(c, 16'h0300, 16, "R12 restart");

    for (int n = 0; n < 40; n++) begin
      lat = 2 + int'($urandom_range(5));
      bl = ($urandom_range(3) == 0) ? 7 : 1 + int'($urandom_range(2));
      c = mk(0, lat, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), bl);
      if (lat == 2 && c[9] && c[8]) c[8] = 1'b0;
      wr_cfg(c); burst(c, 16'($urandom), burst_cycles(c), "R3 R4 R5 R6 R7 R8 R9 random");
    end

    wr_cfg(mk(0, 3, 1, 0, 0, 0, 1) | 16'h4000);
    check(cfg_err && data_valid && wait_o == 1'b0, "R10 reserved bit",
          $sformatf("e=%0b v=%0b w=%0b", cfg_err, data_valid, wait_o), "e=1 v=1 w=0");
    c = mk(0, 3, 1, 0, 0, 1, 1); wr_cfg(c);
    check(cfg_err, "R10 sticky", $sformatf("%0b", cfg_err), "1");
    burst(c, 16'h0020, 10, "R10 valid after error");
    do_reset();
    check(!cfg_err, "R10 reset clears", $sformatf("%0b", cfg_err), "0");
    wr_cfg(mk(0, 3, 1, 0, 0, 0, 4));
    check(cfg_err && data_valid, "R10 bad length", $sformatf("e=%0b v=%0b", cfg_err, data_valid), "e=1 v=1");
    do_reset();
    wr_cfg(mk(0, 1, 1, 0, 0, 0, 1));
    check(cfg_err && data_valid, "R10 bad latency", $sformatf("e=%0b v=%0b", cfg_err, data_valid), "e=1 v=1");
    do_reset();
    wr_cfg(mk(0, 2, 1, 1, 1, 0, 1));
    check(cfg_err && data_valid, "R11 unsupported combo",
          $sformatf("e=%0b v=%0b", cfg_err, data_valid), "e=1 v=1");
    do_reset();
    wr_cfg(mk(0, 2, 1, 1, 0, 0, 1));
    check(!cfg_err && !data_valid, "R11 neighbour accepted",
          $sformatf("e=%0b v=%0b", cfg_err, data_valid), "e=0 v=0");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule